// File: doc/BRIEF.md
# Multiplexed Segment Output Driver

This block turns a stored display image into the logic-level waveforms for a row of LCD segment electrodes. A display image of twice the segment count is held outside the block as two halves, A and B. In static operation every segment follows its bit in half A. In half-duty operation the two common electrodes take turns being selected, and each segment shows its bit from half A while common A is selected and its bit from half B while common B is selected.

A lit segment is driven as the complement of the common waveform, so the voltage across the liquid crystal alternates; a dark segment follows the common waveform, so no voltage builds up. Two test inputs light every segment or darken every segment, with the light-all input taking precedence. When the block is used as a plain parallel output port, the common reference is replaced by a static polarity level, so the stored bits appear unchanged when that level is low and inverted when it is high. All segment outputs are registered on the system clock and change together on one edge.

Top module: `segment_mux_driver`

## Requirements
- R1: With `dutyMode` low and the port mode off, segment n is built from `latchBits[n]` (half A); bits `latchBits[2*SEG_COUNT-1:SEG_COUNT]` (half B) have no effect on any output.
- R2: With `dutyMode` high and the port mode off, segment n is built from `latchBits[n]` while `comBSel` is low (common A selected) and from `latchBits[SEG_COUNT+n]` while `comBSel` is high (common B selected).
- R3: A segment whose chosen bit is 1 (lit) drives the complement of the reference level; one whose bit is 0 (dark) drives the reference level itself. Outside port mode the reference level is `comWave`.
- R4: While `testAllOn` is high every segment is driven lit, whatever the stored bits.
- R5: While `blankAll` is high and `testAllOn` is low every segment is driven dark.
- R6: When `testAllOn` and `blankAll` are both high, the segments are driven lit.
- R7: In the cycle after both test inputs are released the outputs again reflect the stored bits.
- R8: With `expanderEn` high the reference level is `expPolarity` instead of `comWave`, half A is used whatever `dutyMode` and `comBSel` are, so segment n equals `latchBits[n]` when `expPolarity` is low and its complement when high.
- R9: `segOut` is a register: it reads all zeros during reset and otherwise shows, one clock after the inputs are sampled, the value those inputs call for, all bits on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latchBits | input | 2*SEG_COUNT | Stored image; low half is A, high half is B |
| dutyMode | input | 1 | 0 = static, 1 = half-duty multiplexed |
| comWave | input | 1 | Current level of the common waveform |
| comBSel | input | 1 | 1 while common B is in its select phase |
| testAllOn | input | 1 | Light every segment |
| blankAll | input | 1 | Darken every segment |
| expanderEn | input | 1 | Use the outputs as a plain parallel port |
| expPolarity | input | 1 | Port-mode polarity: 0 = bits as stored, 1 = inverted |
| segOut | output | SEG_COUNT | Registered segment drive levels |

## Verification
The properties take the control inputs as synchronous levels that are meaningful on every edge, with `comWave` and `comBSel` allowed to take any pairing, since the block trusts the common generator to keep the phase and the waveform consistent and does not check it. The stimulus changes every input only on the falling clock edge, and sweeps all 128 combinations of the seven control inputs against several data images, so every property sees both legal and unusual pairings of waveform and select without any input changing near the sampling edge.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;

  // Strobes the control decoder hands to the per-segment datapath.
  typedef struct packed {
    logic pickHalfB;  // take the bit from half B instead of half A
    logic forceOn;    // every segment lit
    logic forceOff;   // every segment dark (already masked by forceOn)
    logic refLevel;   // level a dark segment follows
  } segStrobes_t;

endpackage

// File: rtl/segdrv_ctrl.sv
module segdrv_ctrl
  import segdrv_pkg::*;
(
  input  logic        dutyMode,
  input  logic        comWave,
  input  logic        comBSel,
  input  logic        testAllOn,
  input  logic        blankAll,
  input  logic        expanderEn,
  input  logic        expPolarity,
  output segStrobes_t strobes
);

  always_comb begin
    // Port mode never multiplexes; only half-duty with common B selected does.
    strobes.pickHalfB = dutyMode && comBSel && !expanderEn;
    // Light-all wins over blank-all.
    strobes.forceOn   = testAllOn;
    strobes.forceOff  = blankAll && !testAllOn;
    // Port mode swaps the alternating common for a fixed polarity level.
    strobes.refLevel  = expanderEn ? expPolarity : comWave;
  end

endmodule

// File: rtl/segdrv_lanes.sv
module segdrv_lanes
  import segdrv_pkg::*;
#(
  parameter int SEG_COUNT = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  segStrobes_t          strobes,
  input  logic [SEG_COUNT-1:0] halfA,
  input  logic [SEG_COUNT-1:0] halfB,
  output logic [SEG_COUNT-1:0] segOut
);

  logic [SEG_COUNT-1:0] segNext;

  for (genvar n = 0; n < SEG_COUNT; n++) begin : g_lane
    logic pickedBit;
    logic litBit;

    always_comb begin
      pickedBit = strobes.pickHalfB ? halfB[n] : halfA[n];
      if (strobes.forceOn)       litBit = 1'b1;
      else if (strobes.forceOff) litBit = 1'b0;
      else                       litBit = pickedBit;
      // Lit drives against the reference, dark follows it.
      segNext[n] = strobes.refLevel ^ litBit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) segOut <= '0;
    else        segOut <= segNext;
  end

endmodule

// File: rtl/segment_mux_driver.sv
module segment_mux_driver
  import segdrv_pkg::*;
#(
  parameter int SEG_COUNT = 80,
  localparam int LATCH_BITS = 2 * SEG_COUNT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LATCH_BITS-1:0] latchBits,
  input  logic                  dutyMode,
  input  logic                  comWave,
  input  logic                  comBSel,
  input  logic                  testAllOn,
  input  logic                  blankAll,
  input  logic                  expanderEn,
  input  logic                  expPolarity,
  output logic [SEG_COUNT-1:0]  segOut
);

  segStrobes_t strobes;

  segdrv_ctrl ctrl_i (
    .dutyMode    (dutyMode),
    .comWave     (comWave),
    .comBSel     (comBSel),
    .testAllOn   (testAllOn),
    .blankAll    (blankAll),
    .expanderEn  (expanderEn),
    .expPolarity (expPolarity),
    .strobes     (strobes)
  );

  segdrv_lanes #(.SEG_COUNT(SEG_COUNT)) lanes_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .halfA   (latchBits[SEG_COUNT-1:0]),
    .halfB   (latchBits[LATCH_BITS-1:SEG_COUNT]),
    .segOut  (segOut)
  );

endmodule

// File: rtl/segment_mux_driver_chk.sv
module segment_mux_driver_chk #(
  parameter int SEG_COUNT = 80,
  localparam int LATCH_BITS = 2 * SEG_COUNT
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LATCH_BITS-1:0] latchBits,
  input logic                  dutyMode,
  input logic                  comWave,
  input logic                  comBSel,
  input logic                  testAllOn,
  input logic                  blankAll,
  input logic                  expanderEn,
  input logic                  expPolarity,
  input logic [SEG_COUNT-1:0]  segOut
);

  logic [SEG_COUNT-1:0] imgA;
  logic [SEG_COUNT-1:0] imgB;
  logic                 refNow;
  logic                 dataPath;

  assign imgA     = latchBits[SEG_COUNT-1:0];
  assign imgB     = latchBits[LATCH_BITS-1:SEG_COUNT];
  assign refNow   = expanderEn ? expPolarity : comWave;
  assign dataPath = !testAllOn && !blankAll;

  // R1, R3: static uses half A against the common waveform
  a_r1_static_half_a: assert property (@(posedge clk) disable iff (!rst_n)
    (dataPath && !expanderEn && !dutyMode) |=>
      segOut == ($past(imgA) ^ {SEG_COUNT{$past(comWave)}}));

  // R2: common B select takes half B
  a_r2_half_b: assert property (@(posedge clk) disable iff (!rst_n)
    (dataPath && !expanderEn && dutyMode && comBSel) |=>
      segOut == ($past(imgB) ^ {SEG_COUNT{$past(comWave)}}));

  // R2: common A select takes half A
  a_r2_half_a: assert property (@(posedge clk) disable iff (!rst_n)
    (dataPath && !expanderEn && dutyMode && !comBSel) |=>
      segOut == ($past(imgA) ^ {SEG_COUNT{$past(comWave)}}));

  // R4, R6: light-all, also over blank-all
  a_r4_test_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    testAllOn |=> segOut == {SEG_COUNT{~$past(refNow)}});

  // R5: blank-all
  a_r5_blank_all: assert property (@(posedge clk) disable iff (!rst_n)
    (blankAll && !testAllOn) |=> segOut == {SEG_COUNT{$past(refNow)}});

  // R8: port mode
  a_r8_expander: assert property (@(posedge clk) disable iff (!rst_n)
    (dataPath && expanderEn) |=>
      segOut == ($past(imgA) ^ {SEG_COUNT{$past(expPolarity)}}));

  // R9: held at zero in reset
  always @(posedge clk) begin
    if (!rst_n) a_r9_reset_zero: assert (segOut == '0);
  end

endmodule

bind segment_mux_driver segment_mux_driver_chk #(.SEG_COUNT(SEG_COUNT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .latchBits   (latchBits),
  .dutyMode    (dutyMode),
  .comWave     (comWave),
  .comBSel     (comBSel),
  .testAllOn   (testAllOn),
  .blankAll    (blankAll),
  .expanderEn  (expanderEn),
  .expPolarity (expPolarity),
  .segOut      (segOut)
);

// File: tb/segment_mux_driver_tb_top.sv
module segment_mux_driver_tb_top;

  localparam int N  = 80;
  localparam int LB = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LB-1:0] latchBits = '0;
  logic          dutyMode = 1'b0, comWave = 1'b0, comBSel = 1'b0;
  logic          testAllOn = 1'b0, blankAll = 1'b0;
  logic          expanderEn = 1'b0, expPolarity = 1'b0;
  logic [N-1:0]  segOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [N-1:0] expVal;
    string        tag;
  } item_t;
  item_t sbQueue[$];

  always #2 clk = ~clk;  // 250 MHz

  segment_mux_driver #(.SEG_COUNT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .latchBits(latchBits), .dutyMode(dutyMode),
    .comWave(comWave), .comBSel(comBSel), .testAllOn(testAllOn),
    .blankAll(blankAll), .expanderEn(expanderEn), .expPolarity(expPolarity),
    .segOut(segOut)
  );

  // Expected output from the requirements.
  function automatic logic [N-1:0] model(input logic [LB-1:0] d, input logic du,
      input logic cw, input logic bs, input logic t, input logic b,
      input logic ex, input logic ep);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) begin
      logic bitv, lit, refl;
      bitv = (!ex && du && bs) ? d[N+n] : d[n];   // R1 R2 R8
      lit  = t ? 1'b1 : (b ? 1'b0 : bitv);        // R4 R5 R6
      refl = ex ? ep : cw;                        // R3 R8
      r[n] = refl ^ lit;
    end
    return r;
  endfunction

  task automatic drive(input logic [LB-1:0] d, input logic [6:0] c, input string tag);
    item_t it;
    @(negedge clk);
    latchBits   = d;
    dutyMode    = c[0];
    comWave     = c[1];
    comBSel     = c[2];
    testAllOn   = c[3];
    blankAll    = c[4];
    expanderEn  = c[5];
    expPolarity = c[6];
    it.expVal = model(d, c[0], c[1], c[2], c[3], c[4], c[5], c[6]);
    it.tag    = tag;
    sbQueue.push_back(it);
  endtask

  function automatic string pickTag(input logic [6:0] c);
    if (c[3] && c[4]) return "R6";
    if (c[3])         return "R4";
    if (c[4])         return "R5";
    if (c[5])         return "R8";
    if (c[0])         return "R2";
    if (c[1])         return "R3";
    return "R1";
  endfunction

  // Monitor: one result per edge, one cycle after the driver sets inputs (R9).
  always begin
    @(posedge clk);
    #1;
    if (sbQueue.size() > 0) begin
      item_t it;
      it = sbQueue.pop_front();
      compared++;
      if (segOut !== it.expVal) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", it.tag, segOut, it.expVal);
      end
    end
  end

  function automatic logic [LB-1:0] randImg();
    logic [LB-1:0] d;
    for (int k = 0; k < LB; k += 32) d[k +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    logic [LB-1:0] img;
    // R9: reset state with busy inputs
    latchBits = '1; comWave = 1'b1; testAllOn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compared++;
    if (segOut !== '0) begin
      mismatched++;
      $display("FAIL R9: actual %h expected %h", segOut, {N{1'b0}});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive control sweep over several images.
    for (int p = 0; p < 5; p++) begin
      case (p)
        0: img = {{N/2{2'b10}}, {N/2{2'b01}}};
        1: img = {{N{1'b0}}, {N{1'b1}}};
        2: img = {{N{1'b1}}, {N{1'b0}}};
        default: img = randImg();
      endcase
      for (int c = 0; c < 128; c++) drive(img, 7'(c), pickTag(7'(c)));
    end

    // R1: half B changes alone do not move static outputs.
    img = randImg();
    drive(img, 7'b0000010, "R1");
    img[LB-1:N] = ~img[LB-1:N];
    drive(img, 7'b0000010, "R1");

    // R2: walking bit identifies segment-to-bit mapping in both halves.
    for (int n = 0; n < N; n += 13) begin
      img = '0; img[n] = 1'b1; img[N+N-1-n] = 1'b1;
      drive(img, 7'b0000001, "R2");
      drive(img, 7'b0000101, "R2");
    end

    // R7: overrides released return to data.
    img = randImg();
    drive(img, 7'b0011001, "R6");
    drive(img, 7'b0000101, "R7");
    drive(img, 7'b0010000, "R5");
    drive(img, 7'b0000010, "R7");

    // R8: port mode ignores duty, select and common.
    img = randImg();
    drive(img, 7'b0100111, "R8");
    drive(img, 7'b1100111, "R8");

    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule